// File: doc/BRIEF.md
# ADC Conversion Group Channel Sequencer

This block decides which analog input channel the converter should sample next for three conversion groups. Each group has a 32-bit channel select mask, a trigger mode and a 32-entry channel table. A trigger starts a sub-sequence. A sub-sequence contains as many conversions as the mask has set bits. For each conversion the block drives a channel number and a one-cycle start strobe, then waits for the converter's done pulse.

The block has two ways to choose channels. In the default scan mode, it walks the set bits of the mask from low to high. In table mode, it reads the channel from the group's table at a running index. This index persists across sub-sequences. It moves forward by one on every completed conversion, wraps at a programmable limit, and is cleared by several events. When more than one group is pending, the lowest-numbered group goes first. A running sub-sequence is never preempted.

Software reaches every setting through a word-addressed write port and a combinational read port. The address map is as follows:

- Address 0x00 (control):
  - Bit 0 enables table mode.
  - Bit 1 is a soft-reset pulse.
- Address 0x01 (action):
  - Bits [2:0] are software triggers for groups 0 to 2.
  - Bits [6:4] are result-storage resets for groups 0 to 2.
- Group g registers, at 0x08+4g plus an offset:
  - Offset +0 is the mask.
  - Offset +1 is the mode register: bit 0 selects hardware triggering, and bits [3:1] select the event source.
  - Offset +2 is the index.
  - Offset +3 is the wrap limit, in bits [5:0].
- Table entry e of group g is at address 0x80 + 32g + e.

Top module: `adc_grp_seq`

## Requirements
- R1: With mode bit 0 clear (the reset value), a group starts only on its software trigger bit. With mode bit 0 set, software triggers for that group are ignored.
- R2: A trigger for a group whose mask is zero starts nothing.
- R3: A sub-sequence issues exactly as many start strobes as the mask has set bits, and then stops.
- R4: The index starts at 0 after reset. It increments by one on every completed conversion and is read at group offset +2.
- R5: When the incremented index would equal the wrap limit, the index becomes 0. A limit of 0 makes it wrap after 31.
- R6: The index clears to 0 in four cases: a write of zero to the index register, any write to the group mask, a set result-reset bit for the group, and a set soft-reset bit. The soft reset also drops pending and running work.
- R7: In scan mode (control bit 0 clear, the default), the channels of a sub-sequence are the mask's set bit positions in ascending order.
- R8: In table mode, the channel is the low 5 bits of table entry 32g + index, fetched for each conversion. Table entries read back as those 5 bits.
- R9: In hardware mode, a group is triggered by a rising edge, after a two-stage synchronizer, of event input number mode[3:1]. Other event inputs and a level held high do not trigger it.
- R10: Among pending groups the lowest-numbered group is served first. A started sub-sequence runs to completion before any other group begins.
- R11: The start strobe lasts one cycle. The channel is valid with the strobe and held until the done pulse. At most one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| hw_ev | input | 8 | Asynchronous hardware event inputs |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| conv_start | output | 1 | One-cycle request to convert `conv_ch` |
| conv_ch | output | 5 | Channel number to convert |

## Verification
The assertions check the following on every cycle:

- The strobe is a single-cycle pulse.
- The channel is held after the strobe.
- No group is granted with an empty mask or ahead of a lower-numbered pending group.
- The active group stays fixed while its sub-sequence runs.
- The index moves on each accepted done and stays below its limit.

Only the bench scenarios can show the rest: the actual channel order in both modes, the wrap values for each limit, the four ways of clearing the index, and the rejection of wrong event sources, held levels and software triggers in hardware mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W      = 5;
  localparam int NCH       = 1 << CH_W;
  localparam int LUT_DEPTH = 32;
  localparam int IDX_W     = $clog2(LUT_DEPTH);
  localparam int CNT_W     = IDX_W + 1;
  localparam int POS_W     = CH_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} seq_state_e;

  // number of set bits in a select mask
  function automatic logic [POS_W-1:0] ones_in(input logic [NCH-1:0] m);
    logic [POS_W-1:0] c;
    c = '0;
    for (int i = 0; i < NCH; i++) c = c + POS_W'(m[i]);
    return c;
  endfunction

  // lowest set bit at or above a start position
  function automatic logic [CH_W-1:0] scan_from(input logic [NCH-1:0] m,
                                                input logic [POS_W-1:0] from);
    logic [CH_W-1:0] r;
    logic            hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (!hit && m[i] && POS_W'(i) >= from) begin
        r   = CH_W'(i);
        hit = 1'b1;
      end
    return r;
  endfunction

  // next table index with wrap at the programmed limit or at the table end
  function automatic logic [IDX_W-1:0] idx_after(input logic [IDX_W-1:0] idx,
                                                 input logic [CNT_W-1:0] lim);
    logic [CNT_W-1:0] n;
    n = CNT_W'(idx) + CNT_W'(1);
    if (n == lim || n == CNT_W'(LUT_DEPTH)) return '0;
    return n[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NGRP  = 3,
  parameter int SRC_W = 3,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [AW-1:0]                        wr_addr,
  input  logic [DW-1:0]                        wr_data,
  input  logic [AW-1:0]                        rd_addr,
  output logic [DW-1:0]                        rd_data,
  input  logic [NGRP-1:0][IDX_W-1:0]           cur_idx_i,
  output logic                                 lookup_en_o,
  output logic                                 soft_rst_o,
  output logic [NGRP-1:0]                      sw_trig_o,
  output logic [NGRP-1:0]                      idx_clr_o,
  output logic [NGRP-1:0]                      mask_wr_o,
  output logic [NGRP-1:0]                      hw_mode_o,
  output logic [NGRP-1:0][NCH-1:0]             mask_o,
  output logic [NGRP-1:0][SRC_W-1:0]           src_o,
  output logic [NGRP-1:0][CNT_W-1:0]           max_o,
  output logic [NGRP*LUT_DEPTH-1:0][CH_W-1:0]  lut_o
);
  localparam int NLUT   = NGRP * LUT_DEPTH;
  localparam int A_CTRL = 0;
  localparam int A_ACT  = 1;
  localparam int A_GRP  = 8;
  localparam int A_LUT  = 128;

  function automatic logic [AW-1:0] greg(input int g, input int off);
    return AW'(A_GRP + 4 * g + off);
  endfunction

  logic act_wr;
  assign act_wr     = wr_en && (wr_addr == AW'(A_ACT));
  assign soft_rst_o = wr_en && (wr_addr == AW'(A_CTRL)) && wr_data[1];

  for (genvar g = 0; g < NGRP; g++) begin : g_pulse
    assign sw_trig_o[g] = act_wr && wr_data[g];
    assign mask_wr_o[g] = wr_en && (wr_addr == greg(g, 0));
    assign idx_clr_o[g] = mask_wr_o[g] || (act_wr && wr_data[4+g]) ||
                          (wr_en && (wr_addr == greg(g, 2)) && (wr_data == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lookup_en_o <= 1'b0;
      hw_mode_o   <= '0;
      mask_o      <= '0;
      src_o       <= '0;
      max_o       <= '0;
      lut_o       <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) lookup_en_o <= wr_data[0];
      for (int g = 0; g < NGRP; g++) begin
        if (wr_addr == greg(g, 0)) mask_o[g] <= wr_data[NCH-1:0];
        if (wr_addr == greg(g, 1)) begin
          hw_mode_o[g] <= wr_data[0];
          src_o[g]     <= wr_data[SRC_W:1];
        end
        if (wr_addr == greg(g, 3)) max_o[g] <= wr_data[CNT_W-1:0];
      end
      for (int e = 0; e < NLUT; e++)
        if (wr_addr == AW'(A_LUT + e)) lut_o[e] <= wr_data[CH_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTRL)) rd_data[0] = lookup_en_o;
    for (int g = 0; g < NGRP; g++) begin
      if (rd_addr == greg(g, 0)) rd_data = DW'(mask_o[g]);
      if (rd_addr == greg(g, 1)) rd_data = DW'({src_o[g], hw_mode_o[g]});
      if (rd_addr == greg(g, 2)) rd_data = DW'(cur_idx_i[g]);
      if (rd_addr == greg(g, 3)) rd_data = DW'(max_o[g]);
    end
    for (int e = 0; e < NLUT; e++)
      if (rd_addr == AW'(A_LUT + e)) rd_data = DW'(lut_o[e]);
  end
endmodule

// File: rtl/adc_seq_evsync.sv
module adc_seq_evsync #(
  parameter int NGRP  = 3,
  parameter int NEV   = 8,
  parameter int SRC_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NEV-1:0]             ev_i,
  input  logic [NGRP-1:0]            hw_mode_i,
  input  logic [NGRP-1:0][SRC_W-1:0] src_i,
  output logic [NGRP-1:0]            rise_o
);
  logic [NEV-1:0] s1, s2, s3, edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= ev_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_w = s2 & ~s3;

  for (genvar g = 0; g < NGRP; g++) begin : g_sel
    assign rise_o[g] = hw_mode_i[g] && edge_w[src_i[g]];
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NGRP = 3,
  parameter int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NGRP-1:0][NCH-1:0]            mask_i,
  input  logic [NGRP-1:0][CNT_W-1:0]          max_i,
  input  logic [NGRP*LUT_DEPTH-1:0][CH_W-1:0] lut_i,
  input  logic                                lookup_en_i,
  input  logic [NGRP-1:0]                     hw_mode_i,
  input  logic [NGRP-1:0]                     sw_trig_i,
  input  logic [NGRP-1:0]                     rise_i,
  input  logic [NGRP-1:0]                     idx_clr_i,
  input  logic [NGRP-1:0]                     mask_wr_i,
  input  logic                                soft_rst_i,
  input  logic                                conv_done_i,
  output logic                                conv_start_o,
  output logic [CH_W-1:0]                     conv_ch_o,
  output logic [NGRP-1:0][IDX_W-1:0]          cur_idx_o,
  output logic [NGRP-1:0]                     pend_o,
  output logic                                grant_o,
  output logic [GW-1:0]                       grant_grp_o,
  output logic [GW-1:0]                       act_grp_o,
  output logic                                busy_o,
  output logic                                done_acc_o
);
  localparam int LW = $clog2(NGRP * LUT_DEPTH);

  seq_state_e       state;
  logic [POS_W-1:0] remain, seq_pos;
  logic [NGRP-1:0]  pend_set, grant_hot;
  logic [LW-1:0]    lut_sel;
  logic [CH_W-1:0]  fetch_ch;

  for (genvar g = 0; g < NGRP; g++) begin : g_set
    assign pend_set[g] = (|mask_i[g]) && (hw_mode_i[g] ? rise_i[g] : sw_trig_i[g]);
  end

  always_comb begin
    grant_grp_o = '0;
    for (int g = NGRP - 1; g >= 0; g--)
      if (pend_o[g]) grant_grp_o = GW'(g);
  end

  assign grant_o    = (state == S_IDLE) && (|pend_o);
  assign grant_hot  = grant_o ? (NGRP'(1) << grant_grp_o) : '0;
  assign busy_o     = (state != S_IDLE);
  assign done_acc_o = (state == S_WAIT) && conv_done_i;

  assign lut_sel  = LW'(act_grp_o) * LW'(LUT_DEPTH) + LW'(cur_idx_o[act_grp_o]);
  assign fetch_ch = lookup_en_i ? lut_i[lut_sel] : scan_from(mask_i[act_grp_o], seq_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else if (soft_rst_i) pend_o <= '0;
    else pend_o <= (pend_o | pend_set) & ~mask_wr_i & ~grant_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      act_grp_o    <= '0;
      remain       <= '0;
      seq_pos      <= '0;
      conv_ch_o    <= '0;
      conv_start_o <= 1'b0;
    end else if (soft_rst_i) begin
      state        <= S_IDLE;
      conv_start_o <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (grant_o) begin
          act_grp_o <= grant_grp_o;
          remain    <= ones_in(mask_i[grant_grp_o]);
          seq_pos   <= '0;
          state     <= S_FETCH;
        end
        S_FETCH: begin
          conv_ch_o    <= fetch_ch;
          seq_pos      <= POS_W'(fetch_ch) + POS_W'(1);
          conv_start_o <= 1'b1;
          state        <= S_WAIT;
        end
        S_WAIT: begin
          conv_start_o <= 1'b0;
          if (conv_done_i) begin
            if (remain <= POS_W'(1)) state <= S_IDLE;
            else begin
              remain <= remain - POS_W'(1);
              state  <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_idx_o <= '0;
    else begin
      for (int g = 0; g < NGRP; g++) begin
        if (soft_rst_i || idx_clr_i[g]) cur_idx_o[g] <= '0;
        else if (done_acc_o && act_grp_o == GW'(g))
          cur_idx_o[g] <= idx_after(cur_idx_o[g], max_i[g]);
      end
    end
  end
endmodule

// File: rtl/adc_grp_seq.sv
module adc_grp_seq
  import adc_seq_pkg::*;
#(
  parameter int NGRP = 3,
  parameter int NEV  = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NEV-1:0]  hw_ev,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch
);
  localparam int SRC_W = $clog2(NEV);
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic                                lookup_en, soft_rst;
  logic [NGRP-1:0]                     sw_trig, idx_clr, mask_wr, hw_mode, rise, pend;
  logic [NGRP-1:0][NCH-1:0]            mask;
  logic [NGRP-1:0][SRC_W-1:0]          src;
  logic [NGRP-1:0][CNT_W-1:0]          max_cnt;
  logic [NGRP*LUT_DEPTH-1:0][CH_W-1:0] lut;
  logic [NGRP-1:0][IDX_W-1:0]          cur_idx;
  logic                                grant, busy, done_acc;
  logic [GW-1:0]                       grant_grp, act_grp;

  adc_seq_regs #(.NGRP(NGRP), .SRC_W(SRC_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_idx_i(cur_idx),
    .lookup_en_o(lookup_en), .soft_rst_o(soft_rst), .sw_trig_o(sw_trig),
    .idx_clr_o(idx_clr), .mask_wr_o(mask_wr), .hw_mode_o(hw_mode), .mask_o(mask),
    .src_o(src), .max_o(max_cnt), .lut_o(lut)
  );

  adc_seq_evsync #(.NGRP(NGRP), .NEV(NEV), .SRC_W(SRC_W)) u_ev (
    .clk(clk), .rst_n(rst_n), .ev_i(hw_ev), .hw_mode_i(hw_mode), .src_i(src),
    .rise_o(rise)
  );

  adc_seq_core #(.NGRP(NGRP), .GW(GW)) u_core (
    .clk(clk), .rst_n(rst_n), .mask_i(mask), .max_i(max_cnt), .lut_i(lut),
    .lookup_en_i(lookup_en), .hw_mode_i(hw_mode), .sw_trig_i(sw_trig), .rise_i(rise),
    .idx_clr_i(idx_clr), .mask_wr_i(mask_wr), .soft_rst_i(soft_rst),
    .conv_done_i(conv_done), .conv_start_o(conv_start), .conv_ch_o(conv_ch),
    .cur_idx_o(cur_idx), .pend_o(pend), .grant_o(grant), .grant_grp_o(grant_grp),
    .act_grp_o(act_grp), .busy_o(busy), .done_acc_o(done_acc)
  );
endmodule

// File: rtl/adc_grp_seq_chk.sv
module adc_grp_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int NGRP = 3,
  parameter int GW   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       conv_start,
  input logic [CH_W-1:0]            conv_ch,
  input logic                       busy,
  input logic                       grant,
  input logic [GW-1:0]              grant_grp,
  input logic [GW-1:0]              act_grp,
  input logic [NGRP-1:0]            pend,
  input logic [NGRP-1:0][NCH-1:0]   mask,
  input logic [NGRP-1:0][IDX_W-1:0] cur_idx,
  input logic [NGRP-1:0][CNT_W-1:0] max_cnt,
  input logic [NGRP-1:0]            idx_clr,
  input logic                       soft_rst,
  input logic                       done_acc
);
  logic [IDX_W-1:0] act_idx;
  logic [CNT_W-1:0] act_max;
  logic [NGRP-1:0]  lower;
  assign act_idx = cur_idx[act_grp];
  assign act_max = max_cnt[act_grp];
  assign lower   = (NGRP'(1) << grant_grp) - NGRP'(1);

  a_r11_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r11_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> $stable(conv_ch));
  a_r11_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  a_r2_no_empty_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (mask[grant_grp] != '0));
  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ((pend & lower) == '0));
  a_r10_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst) |=> $stable(act_grp));
  a_r4_index_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && !soft_rst && !idx_clr[act_grp] && act_max != CNT_W'(1))
      |=> act_idx != $past(act_idx));
  a_r5_index_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && CNT_W'(act_idx) < act_max) |=> CNT_W'(act_idx) < $past(act_max));
endmodule

bind adc_grp_seq adc_grp_seq_chk #(.NGRP(NGRP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_ch(conv_ch), .busy(busy),
  .grant(grant), .grant_grp(grant_grp), .act_grp(act_grp), .pend(pend), .mask(mask),
  .cur_idx(cur_idx), .max_cnt(max_cnt), .idx_clr(idx_clr), .soft_rst(soft_rst),
  .done_acc(done_acc)
);

// File: tb/adc_grp_seq_tb.sv
module adc_grp_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  hw_ev = '0;
  logic        conv_done = 1'b0;
  logic        conv_start;
  logic [4:0]  conv_ch;

  int checks = 0;
  int errors = 0;
  int nconv  = 0;

  always #2 clk = ~clk;

  adc_grp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hw_ev(hw_ev), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch)
  );

  function automatic int gaddr(input int g, input int off);
    return 8 + 4 * g + off;
  endfunction
  function automatic int lutv(input int g, input int e);
    return (g * 11 + e * 7 + 3) % 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = 8'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic chk_idx(input int g, input int exp, input string tag);
    int v;
    rd(gaddr(g, 2), v);
    chk(v == exp, tag, v, exp);
  endtask

  // wait for one strobe, check its channel, answer with done; optional trigger mid-flight
  task automatic conv(input int exp, input string tag, input int inj = 0);
    int t;
    t = 0;
    @(negedge clk);
    while (!conv_start && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(conv_start == 1'b1, {tag, " strobe"}, int'(conv_start), 1);
    chk(int'(conv_ch) == exp, tag, int'(conv_ch), exp);
    if (inj != 0) wr(1, inj);
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic no_start(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_start) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int v;
    int m;
    int mx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk(conv_start == 1'b0, "R11 reset strobe low", int'(conv_start), 0);
    for (int g = 0; g < 3; g++) chk_idx(g, 0, "R4 reset index");
    rd(0, v);
    chk(v == 0, "R7 scan mode is default", v, 0);
    no_start(20, "R1 no start without trigger");

    // scan mode: example mask, then a sweep of masks
    wr(gaddr(0, 0), 32'hA000_0003);
    wr(1, 1);
    conv(0, "R7 scan ch0");
    conv(1, "R7 scan ch1");
    conv(29, "R7 scan ch29");
    conv(31, "R7 scan ch31");
    no_start(30, "R3 four conversions only");
    chk_idx(0, 4, "R4 index counts conversions");
    for (int k = 0; k < 6; k++) begin
      m = (1 << k) | (32'h8000_0000 >> (2 * k)) | (32'h0001_0000 << k);
      wr(gaddr(0, 0), m);
      wr(1, 1);
      nconv = 0;
      for (int b = 0; b < 32; b++)
        if (m[b]) begin
          conv(b, "R7 scan sweep");
          nconv++;
        end
      no_start(20, "R3 sweep length");
      chk_idx(0, nconv, "R6 mask write restarts index");
    end
    wr(gaddr(0, 2), 0);
    chk_idx(0, 0, "R6 zero write clears index");

    // empty mask
    wr(1, 4);
    no_start(30, "R2 empty mask trigger ignored");

    // table mode
    for (int g = 0; g < 3; g++)
      for (int e = 0; e < 32; e++) wr(128 + 32 * g + e, 32'hFFE0 | lutv(g, e));
    rd(128 + 32 + 7, v);
    chk(v == lutv(1, 7), "R8 table readback low bits", v, lutv(1, 7));
    rd(128 + 64 + 31, v);
    chk(v == lutv(2, 31), "R8 table readback last", v, lutv(2, 31));
    wr(0, 1);
    wr(gaddr(1, 0), 32'h0010_0101);
    wr(gaddr(1, 3), 5);
    for (int n = 0; n < 12; n++) begin
      if (n % 3 == 0) wr(1, 2);
      conv(lutv(1, n % 5), "R8 table channel");
    end
    chk_idx(1, 2, "R5 wrap at limit 5");

    // limit sweep
    wr(gaddr(2, 0), 32'h0000_0040);
    for (mx = 1; mx <= 6; mx++) begin
      wr(gaddr(2, 3), mx);
      wr(gaddr(2, 2), 0);
      for (int n = 0; n <= mx; n++) begin
        wr(1, 4);
        conv(lutv(2, n % mx), "R5 limit sweep channel");
      end
      chk_idx(2, (mx + 1) % mx, "R5 limit sweep index");
    end

    // limit zero wraps after the last entry
    wr(gaddr(0, 0), 32'h0000_0100);
    wr(gaddr(0, 3), 0);
    for (int n = 0; n < 33; n++) begin
      wr(1, 1);
      conv(lutv(0, n % 32), "R5 full-table wrap channel");
    end
    chk_idx(0, 1, "R5 limit zero wraps at 32");

    // clear events
    wr(1, 1 << 4);
    chk_idx(0, 0, "R6 result reset clears index");
    wr(1, 1);
    conv(lutv(0, 0), "R8 channel after clear");
    chk_idx(0, 1, "R4 index after one");
    wr(0, 3);
    chk_idx(0, 0, "R6 soft reset clears index");
    chk_idx(1, 0, "R6 soft reset clears other group");

    // hardware trigger on group 1, source 5
    wr(gaddr(1, 1), (5 << 1) | 1);
    wr(1, 2);
    no_start(30, "R1 software trigger ignored in hw mode");
    @(negedge clk); hw_ev[4] = 1'b1;
    repeat (3) @(negedge clk); hw_ev[4] = 1'b0;
    no_start(30, "R9 other source ignored");
    @(negedge clk); hw_ev[5] = 1'b1;
    for (int n = 0; n < 3; n++) conv(lutv(1, n), "R9 hw triggered channel");
    no_start(40, "R9 held level is one trigger");
    hw_ev[5] = 1'b0;
    repeat (4) @(negedge clk);
    hw_ev[5] = 1'b1;
    conv(lutv(1, 3), "R9 second edge ch");
    conv(lutv(1, 4), "R9 second edge ch");
    conv(lutv(1, 0), "R9 second edge wraps");
    hw_ev[5] = 1'b0;
    wr(gaddr(1, 1), 0);

    // priority and non-preemption in scan mode
    wr(0, 0);
    wr(gaddr(0, 0), 1 << 3);
    wr(gaddr(1, 0), 1 << 10);
    wr(gaddr(2, 0), 3 << 20);
    wr(1, 7);
    conv(3, "R10 group 0 first");
    conv(10, "R10 group 1 second");
    conv(20, "R10 group 2 third");
    conv(21, "R10 group 2 third");
    wr(1, 4);
    conv(20, "R10 running group", 1);
    conv(21, "R10 not preempted");
    conv(3, "R10 waiting group after");
    no_start(20, "R3 nothing left pending");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule